// File: doc/BRIEF.md
# Sub-Interrupt Aggregator With Parent Mapping

This block gathers up to 32 second-level interrupt sources, such as the receive, transmit and error events of several serial ports, touch and converter events, and camera events. It keeps one pending bit and one mask bit for each source. It reduces the sources to one request line for each of a fixed set of parent positions in a main interrupt controller. A source feeds its parent only while it is pending and its mask bit is 0.

Software reaches the two registers through a small register port. Reads are combinational and return the pending word at offset 0x18 or the mask word at offset 0x1c. Writes take effect on the clock edge. The block does not arbitrate among parents; the main controller does that.

Top module: `subint_aggregator`

## Requirements
- R1: In the cycle after reset is released, every mask bit reads 1, every pending bit reads 0 and every parent request is 0.
- R2: All valid sources other than 9 and 10 are level type. Each such source sets its pending bit at every clock edge where its request input is high.
- R3: Sources 9 and 10 are edge type. Each sets its pending bit only at an edge where its request is high and was low at the previous edge. A request held high after its bit is cleared does not set the bit again.
- R4: A write to offset 0x18 clears each pending bit whose write-data bit is 1 and leaves the others unchanged. If a source sets its bit at the same edge, the bit stays 1.
- R5: A write to offset 0x1c replaces the whole mask word. A mask bit of 1 blocks its source. Reads return the pending word at 0x18, the mask word at 0x1c and zero at any other offset.
- R6: Each source feeds a fixed parent. Sources 0-2 feed parent 28, 3-5 feed 23, 6-8 feed 15, 9-10 feed 31, 11-12 feed 6, 14-17 feed 16, 18-23 feed 17, 24-26 feed 18 and 27-28 feed 9. A parent output is 1 exactly when some source in its group is both pending and unmasked.
- R7: A parent output drops as soon as every source in its group is masked, even if those sources are still pending.
- R8: Positions 13, 29, 30 and 31 are reserved. They always read 0 in the pending word and never affect any parent.
- R9: A parent position with no sources mapped to it never asserts its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sub_req | input | 32 | Raw request of each source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| parent_req | output | 32 | Request line for each parent position |

## Verification
The assertions assume the following about the inputs:
- sub_req and the register port are synchronous to clk and stable at each edge.
- A source's request may change at any cycle, including the cycle in which software clears or masks that source.
- The edge-capture check relies on the previous request being low after reset.

The stimulus changes all inputs just after a clock edge. It drives reserved positions as well as valid ones. It deliberately overlaps clears and masks with active requests, so the set-wins and mask-while-pending cases come up. The random phase then mixes requests, clears and mask writes freely.

// File: rtl/subint_pkg.sv
// Package: source-to-parent mapping and source type for the aggregator.
// Assumes at most 64 sources; a source index with no parent is reserved.
package subint_pkg;

    localparam int NO_PARENT = -1;

    // Parent position that a source index feeds, or NO_PARENT when reserved.
    function automatic int parent_of(input int s);
        if (s >= 0 && s <= 2)        return 28;
        else if (s >= 3 && s <= 5)   return 23;
        else if (s >= 6 && s <= 8)   return 15;
        else if (s == 9 || s == 10)  return 31;
        else if (s == 11 || s == 12) return 6;
        else if (s >= 14 && s <= 17) return 16;
        else if (s >= 18 && s <= 23) return 17;
        else if (s >= 24 && s <= 26) return 18;
        else if (s == 27 || s == 28) return 9;
        else                         return NO_PARENT;
    endfunction

    // True for sources that latch on a rising request instead of a level.
    function automatic bit is_edge(input int s);
        return (s == 9) || (s == 10);
    endfunction

    // Bit vector of the sources (below nsub) that feed parent p.
    function automatic logic [63:0] group_bits(input int p, input int nsub);
        logic [63:0] g;
        g = '0;
        for (int s = 0; s < nsub; s++)
            if (parent_of(s) == p) g[s] = 1'b1;
        return g;
    endfunction

endpackage

// File: rtl/subint_capture.sv
// Holds one pending bit per source.
// Level sources set while their request is high. Edge sources set on a rising request.
// A clear and a set at the same edge leave the bit set. Reserved positions are tied to 0.
// Assumes sub_req is synchronous to clk.
module subint_capture #(
    parameter int NSUB = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUB-1:0] sub_req,
    input  logic [NSUB-1:0] clr_vec,
    output logic [NSUB-1:0] pend
);
    import subint_pkg::*;

    for (genvar i = 0; i < NSUB; i++) begin : g_src
        if (parent_of(i) == NO_PARENT) begin : g_rsvd
            assign pend[i] = 1'b0;
        end else begin : g_live
            logic set_now;
            if (is_edge(i)) begin : g_edge
                logic req_q;
                // Remember the request seen at the previous edge.
                always_ff @(posedge clk) begin
                    if (!rst_n) req_q <= 1'b0;
                    else        req_q <= sub_req[i];
                end
                assign set_now = sub_req[i] & ~req_q;

                a_r3_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
                    (sub_req[i] && !req_q) |=> pend[i]);
                a_r3_no_reset_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
                    (req_q && clr_vec[i]) |=> !pend[i]);
            end else begin : g_level
                assign set_now = sub_req[i];

                a_r2_level_capture: assert property (@(posedge clk) disable iff (!rst_n)
                    sub_req[i] |=> pend[i]);
            end

            // Pending bit: a set beats a clear; otherwise hold until cleared.
            always_ff @(posedge clk) begin
                if (!rst_n) pend[i] <= 1'b0;
                else        pend[i] <= set_now | (pend[i] & ~clr_vec[i]);
            end

            a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_vec[i] && !sub_req[i]) |=> !pend[i]);
        end
    end

endmodule

// File: rtl/subint_regs.sv
// Register port: the mask register, the write-1-to-clear decode for pending,
// and the combinational read mux. Assumes one access per cycle.
module subint_regs #(
    parameter int          NSUB     = 32,
    parameter int          AW       = 8,
    parameter int unsigned PEND_OFS = 'h18,
    parameter int unsigned MASK_OFS = 'h1c
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [NSUB-1:0] reg_wdata,
    input  logic [NSUB-1:0] pend,
    output logic [NSUB-1:0] mask,
    output logic [NSUB-1:0] clr_vec,
    output logic [NSUB-1:0] reg_rdata
);
    localparam logic [AW-1:0] A_PEND = PEND_OFS[AW-1:0];
    localparam logic [AW-1:0] A_MASK = MASK_OFS[AW-1:0];

    logic hit_pend, hit_mask;
    assign hit_pend = (reg_addr == A_PEND);
    assign hit_mask = (reg_addr == A_MASK);

    // Clear strobes for the pending bits selected by a pending-word write.
    assign clr_vec = (reg_wr && hit_pend) ? reg_wdata : '0;

    // Mask register: every bit is 1 at reset, and a write replaces the whole word.
    always_ff @(posedge clk) begin
        if (!rst_n)                mask <= '1;
        else if (reg_wr && hit_mask) mask <= reg_wdata;
    end

    // Read mux: the pending word, the mask word, or zero.
    always_comb begin
        if (hit_pend)      reg_rdata = pend;
        else if (hit_mask) reg_rdata = mask;
        else               reg_rdata = '0;
    end

    a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && hit_mask) |=> (mask == $past(reg_wdata)));
    a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && hit_mask) |=> $stable(mask));

endmodule

// File: rtl/subint_parent_or.sv
// Reduces pending-and-unmasked sources to one request per parent position.
// The group of each parent is fixed at elaboration. Purely combinational.
module subint_parent_or #(
    parameter int NSUB = 32,
    parameter int NPAR = 32
) (
    input  logic [NSUB-1:0] pend,
    input  logic [NSUB-1:0] mask,
    output logic [NPAR-1:0] parent_req
);
    import subint_pkg::*;

    logic [NSUB-1:0] live;
    assign live = pend & ~mask;

    for (genvar p = 0; p < NPAR; p++) begin : g_par
        localparam logic [63:0]     GRP64 = group_bits(p, NSUB);
        localparam logic [NSUB-1:0] GRP   = GRP64[NSUB-1:0];
        if (GRP == '0) begin : g_none
            assign parent_req[p] = 1'b0;
        end else begin : g_any
            assign parent_req[p] = |(live & GRP);
        end
    end

endmodule

// File: rtl/subint_aggregator.sv
// Top of the sub-interrupt aggregator.
// Holds pending and mask registers for NSUB sources and drives NPAR parent request lines.
// Assumes the source-to-parent mapping in subint_pkg fits within NSUB and NPAR.
module subint_aggregator #(
    parameter int          NSUB     = 32,
    parameter int          NPAR     = 32,
    parameter int          AW       = 8,
    parameter int unsigned PEND_OFS = 'h18,
    parameter int unsigned MASK_OFS = 'h1c
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSUB-1:0] sub_req,
    input  logic            reg_wr,
    input  logic [AW-1:0]   reg_addr,
    input  logic [NSUB-1:0] reg_wdata,
    output logic [NSUB-1:0] reg_rdata,
    output logic [NPAR-1:0] parent_req
);
    logic [NSUB-1:0] pend, mask, clr_vec;

    subint_capture #(.NSUB(NSUB)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .sub_req (sub_req),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    subint_regs #(
        .NSUB(NSUB), .AW(AW), .PEND_OFS(PEND_OFS), .MASK_OFS(MASK_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pend      (pend),
        .mask      (mask),
        .clr_vec   (clr_vec),
        .reg_rdata (reg_rdata)
    );

    subint_parent_or #(.NSUB(NSUB), .NPAR(NPAR)) u_parent (
        .pend       (pend),
        .mask       (mask),
        .parent_req (parent_req)
    );

    // With every source masked, no parent may request, whatever is pending.
    a_r7_all_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '1) |-> (parent_req == '0));
    // A parent output needs at least one pending source somewhere.
    a_r6_parent_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |-> (parent_req == '0));

endmodule

// File: tb/subint_aggregator_bench.sv
module subint_aggregator_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sub_req = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] parent_req;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_pend, m_mask, m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    subint_aggregator u_subint_aggregator (
        .clk(clk), .rst_n(rst_n), .sub_req(sub_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .parent_req(parent_req)
    );

    // Expected parent of a source, taken from the requirements; -1 means reserved.
    function automatic int exp_parent(input int s);
        case (s)
            0, 1, 2:                return 28;
            3, 4, 5:                return 23;
            6, 7, 8:                return 15;
            9, 10:                  return 31;
            11, 12:                 return 6;
            14, 15, 16, 17:         return 16;
            18, 19, 20, 21, 22, 23: return 17;
            24, 25, 26:             return 18;
            27, 28:                 return 9;
            default:                return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_parents();
        logic [31:0] r = '0;
        for (int s = 0; s < 32; s++)
            if (exp_parent(s) >= 0 && m_pend[s] && !m_mask[s]) r[exp_parent(s)] = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] exp_read();
        if (reg_addr == 8'h18) return m_pend;
        if (reg_addr == 8'h1c) return m_mask;
        return '0;
    endfunction

    task automatic compare(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock: update the model from the current inputs, then compare just after the edge.
    task automatic step(input string tag);
        logic [31:0] np;
        np = m_pend;
        for (int s = 0; s < 32; s++) begin
            logic setb, clrb;
            setb = (s == 9 || s == 10) ? (sub_req[s] && !m_prev[s]) : sub_req[s];
            clrb = reg_wr && reg_addr == 8'h18 && reg_wdata[s];
            np[s] = (exp_parent(s) >= 0) && (setb || (m_pend[s] && !clrb));
        end
        if (reg_wr && reg_addr == 8'h1c) m_mask = reg_wdata;
        m_pend = np;
        m_prev = sub_req;
        @(posedge clk);
        #1;
        compare(tag, "parent_req", parent_req, exp_parents());
        compare(tag, "reg_rdata", reg_rdata, exp_read());
    endtask

    task automatic write(input string tag, input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(tag);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_pend = '0; m_mask = '1; m_prev = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state of the mask and pending words and the parents.
        reg_addr = 8'h1c; step("R1");
        reg_addr = 8'h18; step("R1");
        // R5: unmask everything, read the mask back, then read an unused offset.
        write("R5", 8'h1c, 32'h0000_0000);
        reg_addr = 8'h1c; step("R5");
        reg_addr = 8'h40; step("R5");
        reg_addr = 8'h18;
        // R2/R6: a one-cycle level pulse on source 0 stays pending and raises parent 28.
        sub_req = 32'h1; step("R2");
        sub_req = '0;    step("R6");
        // R4: write-1-to-clear drops it; a zero bit in the write leaves another source alone.
        sub_req = 32'h8; step("R6");
        sub_req = '0;
        write("R4", 8'h18, 32'h1);
        step("R4");
        // R4: a clear while the level request is held high leaves the bit set.
        sub_req = 32'h40;
        step("R2");
        write("R4", 8'h18, 32'h40);
        sub_req = '0; step("R4");
        write("R4", 8'h18, 32'hffff_ffff);
        // R3: edge source 9 held high, cleared during the hold, does not set again.
        sub_req = 32'h200; step("R3");
        write("R3", 8'h18, 32'h200);
        step("R3"); step("R3");
        sub_req = '0; step("R3");
        sub_req = 32'h400; step("R3");
        sub_req = '0; step("R3");
        write("R3", 8'h18, 32'hffff_ffff);
        // R7: sources 0-2 pending; mask them all and parent 28 drops while pending stays.
        sub_req = 32'h7; step("R7");
        sub_req = '0;
        write("R7", 8'h1c, 32'h0000_0003);
        step("R7");
        write("R7", 8'h1c, 32'h0000_0007);
        step("R7");
        write("R7", 8'h1c, 32'h0);
        write("R7", 8'h18, 32'hffff_ffff);
        // R8/R9: reserved positions never set and never reach a parent.
        sub_req = 32'hE000_2000; step("R8"); step("R8");
        sub_req = '0; step("R9");
        // R6: random requests, clears and mask writes, compared every cycle.
        for (int n = 0; n < 400; n++) begin
            int op;
            sub_req = $urandom;
            op = $urandom_range(0, 5);
            if (op == 0) begin
                reg_wr = 1'b1; reg_addr = 8'h18; reg_wdata = $urandom;
            end else if (op == 1) begin
                reg_wr = 1'b1; reg_addr = 8'h1c; reg_wdata = $urandom;
            end else begin
                reg_wr = 1'b0; reg_addr = (op == 2) ? 8'h1c : 8'h18; reg_wdata = '0;
            end
            step("R6");
        end
        reg_wr = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule